// File: doc/BRIEF.md
# Double-Buffered Parallel Converter Register Front End

This block is the digital side of a 12-bit parallel-input converter. A host reaches it over one bidirectional data bus. The bus is split here into an input word, an output word and an output enable. An active-low select, a direction line and an active-low load strobe control the block. The host writes a staging register and can read that register back. The load strobe moves the staged word into the code register, whose value drives the analog converter.

The code register models a level-sensitive latch in a clocked model. At every rising clock edge where the load strobe is low, the code register takes the staging register's value. If a write happens in that same cycle, it takes the bus word instead, so the data passes straight through. The load strobe works whatever the select line is doing. An active-low clear acts at once, without waiting for a clock edge. It forces the code register to zero and leaves the staging register alone.

Top module: `dacif_front`

## Requirements
- R1: At a rising clock edge where `cs_n`=0 and `rd_wr`=0, the staging register takes `bus_in`. A later read cycle returns that word on `bus_out`.
- R2: At a rising clock edge where a write (`cs_n`=0, `rd_wr`=0) coincides with `load_n`=0 and `clr_n`=1, `dac_code` becomes the `bus_in` word.
- R3: A write with `load_n`=1 leaves `dac_code` unchanged.
- R4: While `cs_n`=0 and `rd_wr`=1, `bus_oe` is 1 and `bus_out` shows the staging register. The staging register is not changed by that cycle.
- R5: At a rising clock edge where `cs_n`=1, `load_n`=0 and `clr_n`=1, `dac_code` takes the staging register value, whatever `rd_wr` and `bus_in` are. The staging register is unchanged.
- R6: With `cs_n`=1 and `load_n`=1, neither register changes.
- R7: `bus_oe` is 1 only when `cs_n`=0 and `rd_wr`=1. Whenever `bus_oe` is 0, `bus_out` is 12'h000.
- R8: While `clr_n`=0, `dac_code` is 12'h000. This takes effect without a clock edge and overrides any load.
- R9: After `clr_n` returns to 1, `dac_code` stays 12'h000 until a rising edge with `load_n`=0. At that edge it takes the staging value.
- R10: With `cs_n`=0, `rd_wr`=1 and `load_n`=0, the cycle is a read plus a load. `dac_code` takes the old staging value and nothing is written.
- R11: The staging register starts at 12'h000 and is not affected by `clr_n`. Bit 11 is the MSB and the coding is straight binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; all sampling at the rising edge |
| clr_n | input | 1 | Active-low clear of the code register, acts without a clock edge |
| cs_n | input | 1 | Active-low select for bus access |
| rd_wr | input | 1 | 1 = read the staging register, 0 = write it |
| load_n | input | 1 | Active-low strobe that moves the staged word into the code register |
| bus_in | input | 12 | Incoming half of the data bus |
| bus_out | output | 12 | Outgoing half of the data bus; 0 when not driven |
| bus_oe | output | 1 | High while the block drives the bus |
| dac_code | output | 12 | Code sent to the analog converter |

## Verification
The bench sweeps all eight combinations of select, direction and load, each under several data words, and compares the result with a register model after each edge.

Several kinds of error would show up there:
- A design that drops the write-through path would load the stale staged word when a write and a load coincide.
- A design that gates the load with the select line would ignore the load when `cs_n` is high.
- A design that writes during a read-and-load cycle would corrupt the readback.

Separate checks cover the clear: clear is asserted between edges and while a load is held low, and it is released with the load both high and low. A clear that waited for a clock edge would fail these checks. So would a clear that also wiped the staging register, or a release that reloaded without the strobe.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

   typedef struct packed {
      logic wr;
      logic rd;
      logic ld;
   } ctl_t;

   typedef enum logic [1:0] {
      BUS_IDLE  = 2'd0,
      BUS_WRITE = 2'd1,
      BUS_READ  = 2'd2
   } bus_op_e;

   function automatic bus_op_e op_of(input logic cs_n, input logic rd_wr);
      if (cs_n)       return BUS_IDLE;
      else if (rd_wr) return BUS_READ;
      else            return BUS_WRITE;
   endfunction

endpackage

// File: rtl/dacif_decode.sv
module dacif_decode
   import dacif_pkg::*;
(
   input  logic cs_n,
   input  logic rd_wr,
   input  logic load_n,
   output ctl_t ctl
);
   bus_op_e op;

   always_comb begin
      op     = op_of(cs_n, rd_wr);
      ctl.wr = (op == BUS_WRITE);
      ctl.rd = (op == BUS_READ);
      ctl.ld = ~load_n;
   end
endmodule

// File: rtl/dacif_stage_reg.sv
module dacif_stage_reg #(
   parameter int unsigned DATA_W = 12
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] q_r = '0;
   logic              primed = 1'b0;

   always_ff @(posedge clk) begin
      primed <= 1'b1;
      if (wr_en) q_r <= d;
   end

   assign q = q_r;

   // R1
   stage_capture_chk: assert property (@(posedge clk) disable iff (!primed)
      wr_en |=> q_r == $past(d));

   // R4
   stage_hold_chk: assert property (@(posedge clk) disable iff (!primed)
      !wr_en |=> $stable(q_r));
endmodule

// File: rtl/dacif_code_reg.sv
module dacif_code_reg #(
   parameter int unsigned         DATA_W     = 12,
   parameter logic [DATA_W-1:0]   CLEAR_CODE = '0
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              ld_en,
   input  logic [DATA_W-1:0] src,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] q_r = CLEAR_CODE;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)     q_r <= CLEAR_CODE;
      else if (ld_en) q_r <= src;
   end

   assign q = q_r;

   // R8
   code_clear_chk: assert property (@(posedge clk)
      !clr_n |-> q_r == CLEAR_CODE);

   // R2
   code_follow_chk: assert property (@(posedge clk) disable iff (!clr_n)
      ld_en |=> q_r == $past(src));

   // R6
   code_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
      !ld_en |=> $stable(q_r));
endmodule

// File: rtl/dacif_bus_port.sv
module dacif_bus_port #(
   parameter int unsigned DATA_W    = 12,
   parameter bit          PARK_ZERO = 1'b1
) (
   input  logic              rd_en,
   input  logic [DATA_W-1:0] stage_q,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe
);
   assign bus_oe = rd_en;

   generate
      if (PARK_ZERO) begin : g_park
         assign bus_out = rd_en ? stage_q : '0;
      end else begin : g_raw
         assign bus_out = stage_q;
      end
   endgenerate
endmodule

// File: rtl/dacif_front.sv
module dacif_front #(
   parameter int unsigned DATA_W        = 12,
   parameter bit          WRITE_THROUGH = 1'b1,
   parameter bit          PARK_ZERO     = 1'b1
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              cs_n,
   input  logic              rd_wr,
   input  logic              load_n,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic [DATA_W-1:0] dac_code
);
   import dacif_pkg::*;

   localparam logic [DATA_W-1:0] ZERO_CODE = '0;

   generate
      if (DATA_W < 2 || DATA_W > 24) begin : g_bad_width
         $error("dacif_front: DATA_W must lie in 2..24");
      end
   endgenerate

   ctl_t              ctl;
   logic [DATA_W-1:0] stage_q;
   logic [DATA_W-1:0] load_src;
   logic              primed = 1'b0;

   always_ff @(posedge clk) primed <= 1'b1;

   dacif_decode u_dec (
      .cs_n   (cs_n),
      .rd_wr  (rd_wr),
      .load_n (load_n),
      .ctl    (ctl)
   );

   dacif_stage_reg #(.DATA_W(DATA_W)) u_stage (
      .clk   (clk),
      .wr_en (ctl.wr),
      .d     (bus_in),
      .q     (stage_q)
   );

   generate
      if (WRITE_THROUGH) begin : g_thru
         assign load_src = ctl.wr ? bus_in : stage_q;
      end else begin : g_staged
         assign load_src = stage_q;
      end
   endgenerate

   dacif_code_reg #(.DATA_W(DATA_W), .CLEAR_CODE(ZERO_CODE)) u_code (
      .clk   (clk),
      .clr_n (clr_n),
      .ld_en (ctl.ld),
      .src   (load_src),
      .q     (dac_code)
   );

   dacif_bus_port #(.DATA_W(DATA_W), .PARK_ZERO(PARK_ZERO)) u_bus (
      .rd_en   (ctl.rd),
      .stage_q (stage_q),
      .bus_out (bus_out),
      .bus_oe  (bus_oe)
   );

   // R4
   read_data_chk: assert property (@(posedge clk)
      bus_oe |-> bus_out == stage_q);

   // R7
   bus_park_chk: assert property (@(posedge clk)
      !bus_oe |-> bus_out == ZERO_CODE);

   // R10
   read_no_write_chk: assert property (@(posedge clk) disable iff (!primed)
      (!cs_n && rd_wr) |=> $stable(stage_q));

   // R5
   idle_stage_chk: assert property (@(posedge clk) disable iff (!primed)
      cs_n |=> $stable(stage_q));
endmodule

// File: tb/dacif_front_tb_top.sv
module dacif_front_tb_top;
   logic        clk = 1'b0;
   logic        clr_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        rd_wr = 1'b1;
   logic        load_n = 1'b1;
   logic [11:0] bus_in = '0;
   logic [11:0] bus_out;
   logic        bus_oe;
   logic [11:0] dac_code;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   logic [11:0] m_stage = '0;
   logic [11:0] m_code  = '0;

   always #4 clk = ~clk;

   dacif_front dut_i (
      .clk      (clk),
      .clr_n    (clr_n),
      .cs_n     (cs_n),
      .rd_wr    (rd_wr),
      .load_n   (load_n),
      .bus_in   (bus_in),
      .bus_out  (bus_out),
      .bus_oe   (bus_oe),
      .dac_code (dac_code)
   );

   task automatic cmp(input string tag, input logic [11:0] act, input logic [11:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string tag_of(input logic c, input logic r, input logic l);
      if (!c && !r && !l) return "R2";
      if (!c && !r &&  l) return "R3";
      if (!c &&  r &&  l) return "R4";
      if (!c &&  r && !l) return "R10";
      if ( c && !l)       return "R5";
      return "R6";
   endfunction

   task automatic step(input logic c, input logic r, input logic l, input logic [11:0] d);
      string t;
      logic  wr;
      logic  oe;
      t = tag_of(c, r, l);
      @(negedge clk);
      cs_n = c; rd_wr = r; load_n = l; bus_in = d;
      wr = !c && !r;
      oe = !c && r;
      @(posedge clk);
      if (clr_n && !l) m_code = wr ? d : m_stage;
      if (!clr_n)      m_code = '0;
      if (wr)          m_stage = d;
      #2;
      cmp({t, " code"}, dac_code, m_code);
      cmp("R7 oe", {11'd0, bus_oe}, {11'd0, oe});
      cmp({t, " bus"}, bus_out, oe ? m_stage : 12'h000);
   endtask

   task automatic readback(input string t);
      step(1'b0, 1'b1, 1'b1, 12'hA5A);
      cmp({t, " readback"}, bus_out, m_stage);
   endtask

   initial begin
      #1600000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1;
      // R11 power-up state, R8 clear held
      cmp("R8 code at start", dac_code, 12'h000);
      cmp("R7 bus idle", bus_out, 12'h000);
      @(negedge clk); clr_n = 1'b1;
      readback("R11");

      // exhaustive sweep over control combinations and data words
      for (int k = 0; k < 6; k++) begin
         for (int cmb = 0; cmb < 8; cmb++) begin
            logic [11:0] w;
            w = 12'((k * 12'h9A5) ^ (cmb << 4) ^ (k << 9));
            step(cmb[2], cmb[1], cmb[0], w);
            step(1'b1, 1'b1, 1'b1, ~w);
         end
      end
      // R1 MSB/LSB and extremes
      step(1'b0, 1'b0, 1'b1, 12'h800); readback("R1");
      step(1'b0, 1'b0, 1'b1, 12'h001); readback("R1");
      step(1'b0, 1'b0, 1'b0, 12'hFFF); readback("R1");
      step(1'b1, 1'b0, 1'b0, 12'h123);

      // R8 clear between edges, without a clock
      @(negedge clk); #1 clr_n = 1'b0; #1;
      cmp("R8 async clear", dac_code, 12'h000);
      // R8 clear overrides a write-through load
      step(1'b0, 1'b0, 1'b0, 12'h3C7);
      step(1'b1, 1'b1, 1'b0, 12'h000);
      readback("R11 clear keeps stage");
      // R9 release with load high: stays zero
      @(negedge clk); clr_n = 1'b1;
      step(1'b1, 1'b1, 1'b1, 12'h000);
      cmp("R9 released, no load", dac_code, 12'h000);
      step(1'b1, 1'b0, 1'b0, 12'hBAD);
      cmp("R9 load after release", dac_code, 12'h3C7);
      // release while load held low
      @(negedge clk); clr_n = 1'b0; load_n = 1'b0; #1;
      cmp("R8 clear during load", dac_code, 12'h000);
      @(negedge clk); clr_n = 1'b1;
      m_code = 12'h000;
      step(1'b1, 1'b1, 1'b0, 12'h000);
      cmp("R9 release with load low", dac_code, 12'h3C7);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule